// File: doc/BRIEF.md
# Per-Context Execution Budget Timers

This block limits how much processor time each of five hardware contexts may use. Each context has its own run-time counter and its own limit. A counter only advances while the scheduler reports that its context is executing. It moves by one step for every sixteen system clocks of execution. When a context's counter reaches its limit, the block asks the scheduler to halt that context. It also raises a one-cycle timeout pulse and sends a fault notification to the master context (context 0).

Software on the master context sets the limits and can clear selected counters through a small write port. Writes that come from any other context are dropped. A periodic system-timer channel can also clear every counter at once with no software involved, for example at the start of each scheduling frame. Together these give each context a fixed share of processor time per frame.

Top module: `ctx_budget_timers`

## Requirements
- R1: After reset, every bit of `halt_req` and `timeout_pulse` is 0, and `fault_to_master` is 0.
- R2: With a nonzero limit L, a context's `halt_req` bit goes high directly after the clock edge that ends its 16·L-th execution cycle since its last clear, and not before.
- R3: A context's sixteen-clock prescale count is kept while that context is not running. Only its own execution cycles count toward the limit, however they are interleaved with other contexts or idle cycles.
- R4: Once `halt_req[i]` is high it stays high, and the counter stops advancing, until context i is cleared or its limit is rewritten.
- R5: `timeout_pulse[i]` is high for exactly the one cycle in which `halt_req[i]` rises. `fault_to_master` is high in any cycle in which some `timeout_pulse` bit is high, and `fault_ctx` then gives the lowest-numbered such context.
- R6: A limit of 0 disables enforcement: that context never raises `halt_req`, however long it runs.
- R7: A write takes effect only when `wr_src_ctx` is 0. Address i (0 to 4) loads the limit of context i from `wr_data`. Address 5 is the clear register. Writes with any other source context change nothing.
- R8: A write to the clear register resets the counter and prescale count of context i exactly when `wr_data[i]` is 1. Contexts whose bit is 0 keep their state.
- R9: When `auto_clr_en` and `auto_clr_strobe` are both high in a cycle, all five contexts are cleared. A strobe while `auto_clr_en` is low has no effect.
- R10: If a clear and a counter step for the same context fall in the same cycle, the clear wins. The counter is left at 0 and a full sixteen execution cycles are needed before the next step.
- R11: Nothing advances while `run_valid` is low or while `run_ctx` is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_valid | input | 1 | A context is executing this cycle |
| run_ctx | input | 3 | Number of the executing context |
| wr_en | input | 1 | Register write strobe |
| wr_src_ctx | input | 3 | Context issuing the write; only 0 is accepted |
| wr_addr | input | 3 | 0 to 4 = limit of that context, 5 = clear register |
| wr_data | input | 16 | Limit value, or per-context clear mask in bits 4:0 |
| auto_clr_en | input | 1 | Enables clearing from the periodic timer channel |
| auto_clr_strobe | input | 1 | Periodic timer channel pulse |
| timeout_pulse | output | 5 | One-cycle pulse per context when its limit is reached |
| halt_req | output | 5 | Per-context halt request to the scheduler (level) |
| fault_to_master | output | 1 | A timeout occurred this cycle |
| fault_ctx | output | 3 | Lowest context with a timeout this cycle |

## Verification
The properties assume the scheduler reports at most one executing context per cycle, as a single `run_ctx` value. They also assume that writes from non-master sources and timer strobes arrive as single-cycle events sampled on the clock. The stability checks only apply in cycles with no execution and no timer clear, so that any change in `halt_req` can only come from a dropped write. The stimulus drives every input on the falling edge and never holds a context in reset-sync limbo: it idles the inputs until the internal reset has been released. It sweeps limits 1 to 4 on every context and covers interleaving, out-of-range context numbers and coinciding clears, all within these assumptions.

// File: rtl/ctxb_pkg.sv
package ctxb_pkg;

  // Per-context control derived from the shared inputs each cycle
  typedef struct packed {
    logic run;     // this context executes this cycle
    logic clr;     // counter and prescale clear
    logic lim_we;  // load a new limit
  } slot_ctl_t;

endpackage

// File: rtl/ctxb_rst_sync.sv
module ctxb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ctxb_wr_decode.sv
module ctxb_wr_decode
  import ctxb_pkg::*;
#(
  parameter int NUM_CTX = 5,
  parameter int CNT_W   = 16,
  parameter int CTX_W   = 3,
  parameter int ADDR_W  = 3
) (
  input  logic                       run_valid,
  input  logic [CTX_W-1:0]           run_ctx,
  input  logic                       wr_en,
  input  logic [CTX_W-1:0]           wr_src_ctx,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CNT_W-1:0]           wr_data,
  input  logic                       auto_clr_en,
  input  logic                       auto_clr_strobe,
  output slot_ctl_t [NUM_CTX-1:0]    ctl
);

  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_CTX);

  logic master_wr;
  logic clr_reg_wr;
  logic auto_clr;

  always_comb begin
    master_wr  = wr_en && (wr_src_ctx == '0);
    clr_reg_wr = master_wr && (wr_addr == CLR_ADDR);
    auto_clr   = auto_clr_en && auto_clr_strobe;
  end

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctl
    always_comb begin
      ctl[i].run    = run_valid && (run_ctx == CTX_W'(i));
      ctl[i].clr    = auto_clr || (clr_reg_wr && wr_data[i]);
      ctl[i].lim_we = master_wr && (wr_addr == ADDR_W'(i));
    end
  end

endmodule

// File: rtl/ctxb_slot.sv
module ctxb_slot
  import ctxb_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_ctl_t        ctl,
  input  logic [CNT_W-1:0] lim_data,
  output logic             halt,
  output logic             timeout
);

  localparam int               PRE_W   = $clog2(PRESCALE);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             exp_prev_q;
  logic             exp_now;
  logic             adv;
  logic             tick;
  logic             run_en;
  logic             lim_en;

  // next-state
  always_comb begin
    exp_now = (lim_q != '0) && (cnt_q >= lim_q);
    adv     = ctl.run && !exp_now;
    tick    = adv && (pre_q == PRE_TOP);
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    if (ctl.clr) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (adv) begin
      if (tick) begin
        pre_d = '0;
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    run_en = ctl.clr || adv;
    lim_en = ctl.lim_we;
    lim_d  = lim_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run_en) begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_prev_q <= 1'b0;
    else        exp_prev_q <= exp_now;
  end

  assign halt    = exp_now;
  assign timeout = exp_now && !exp_prev_q;

endmodule

// File: rtl/ctxb_fault_merge.sv
module ctxb_fault_merge #(
  parameter int NUM_CTX = 5,
  parameter int CTX_W   = 3
) (
  input  logic [NUM_CTX-1:0] pulses,
  output logic               fault,
  output logic [CTX_W-1:0]   fault_ctx
);

  always_comb begin
    fault     = |pulses;
    fault_ctx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (pulses[i]) fault_ctx = CTX_W'(i);
    end
  end

endmodule

// File: rtl/ctx_budget_timers.sv
module ctx_budget_timers
  import ctxb_pkg::*;
#(
  parameter int NUM_CTX  = 5,
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 16,
  parameter int CTX_W    = 3,
  parameter int ADDR_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_valid,
  input  logic [CTX_W-1:0]   run_ctx,
  input  logic               wr_en,
  input  logic [CTX_W-1:0]   wr_src_ctx,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic               auto_clr_en,
  input  logic               auto_clr_strobe,
  output logic [NUM_CTX-1:0] timeout_pulse,
  output logic [NUM_CTX-1:0] halt_req,
  output logic               fault_to_master,
  output logic [CTX_W-1:0]   fault_ctx
);

  logic                      rst_n_int;
  slot_ctl_t [NUM_CTX-1:0]   ctl;

  ctxb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ctxb_wr_decode #(
    .NUM_CTX (NUM_CTX),
    .CNT_W   (CNT_W),
    .CTX_W   (CTX_W),
    .ADDR_W  (ADDR_W)
  ) u_dec (
    .run_valid       (run_valid),
    .run_ctx         (run_ctx),
    .wr_en           (wr_en),
    .wr_src_ctx      (wr_src_ctx),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .auto_clr_en     (auto_clr_en),
    .auto_clr_strobe (auto_clr_strobe),
    .ctl             (ctl)
  );

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
    ctxb_slot #(
      .CNT_W    (CNT_W),
      .PRESCALE (PRESCALE)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .ctl      (ctl[i]),
      .lim_data (wr_data),
      .halt     (halt_req[i]),
      .timeout  (timeout_pulse[i])
    );
  end

  ctxb_fault_merge #(
    .NUM_CTX (NUM_CTX),
    .CTX_W   (CTX_W)
  ) u_flt (
    .pulses    (timeout_pulse),
    .fault     (fault_to_master),
    .fault_ctx (fault_ctx)
  );

endmodule

// File: rtl/ctxb_checker.sv
module ctxb_checker #(
  parameter int NUM_CTX = 5,
  parameter int CNT_W   = 16,
  parameter int CTX_W   = 3,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_valid,
  input logic               wr_en,
  input logic [CTX_W-1:0]   wr_src_ctx,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [CNT_W-1:0]   wr_data,
  input logic               auto_clr_en,
  input logic               auto_clr_strobe,
  input logic [NUM_CTX-1:0] timeout_pulse,
  input logic [NUM_CTX-1:0] halt_req,
  input logic               fault_to_master,
  input logic [CTX_W-1:0]   fault_ctx
);

  logic auto_hit;
  logic mwr;
  assign auto_hit = auto_clr_en && auto_clr_strobe;
  assign mwr      = wr_en && (wr_src_ctx == '0);

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_chk
    logic touch;
    assign touch = auto_hit
                || (mwr && (wr_addr == ADDR_W'(NUM_CTX)) && wr_data[i])
                || (mwr && (wr_addr == ADDR_W'(i)));

    a_r5_pulse_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse[i] |-> halt_req[i]);

    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse[i] |=> !timeout_pulse[i]);

    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req[i] && !touch) |=> halt_req[i]);

    a_r5_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_req[i]) |-> timeout_pulse[i]);
  end

  a_r9_auto_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit |=> (halt_req == '0));

  a_r7_foreign_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_src_ctx != '0) && !run_valid && !auto_hit) |=> $stable(halt_req));

  a_r5_fault_names_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    fault_to_master |-> timeout_pulse[fault_ctx]);

  a_r1_quiet_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_pulse == '0) |-> !fault_to_master);

endmodule

bind ctx_budget_timers ctxb_checker #(
  .NUM_CTX (NUM_CTX),
  .CNT_W   (CNT_W),
  .CTX_W   (CTX_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .run_valid       (run_valid),
  .wr_en           (wr_en),
  .wr_src_ctx      (wr_src_ctx),
  .wr_addr         (wr_addr),
  .wr_data         (wr_data),
  .auto_clr_en     (auto_clr_en),
  .auto_clr_strobe (auto_clr_strobe),
  .timeout_pulse   (timeout_pulse),
  .halt_req        (halt_req),
  .fault_to_master (fault_to_master),
  .fault_ctx       (fault_ctx)
);

// File: tb/sim_ctx_budget_timers.sv
`timescale 1ns/1ps
module sim_ctx_budget_timers;

  localparam int N = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_valid;
  logic [2:0]  run_ctx;
  logic        wr_en;
  logic [2:0]  wr_src_ctx;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        auto_clr_en;
  logic        auto_clr_strobe;
  logic [4:0]  timeout_pulse;
  logic [4:0]  halt_req;
  logic        fault_to_master;
  logic [2:0]  fault_ctx;

  always #2.5 clk = ~clk;

  ctx_budget_timers u0 (
    .clk (clk), .rst_n (rst_n),
    .run_valid (run_valid), .run_ctx (run_ctx),
    .wr_en (wr_en), .wr_src_ctx (wr_src_ctx), .wr_addr (wr_addr), .wr_data (wr_data),
    .auto_clr_en (auto_clr_en), .auto_clr_strobe (auto_clr_strobe),
    .timeout_pulse (timeout_pulse), .halt_req (halt_req),
    .fault_to_master (fault_to_master), .fault_ctx (fault_ctx)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // requirement-level reference state
  int m_pre [N];
  int m_cnt [N];
  int m_lim [N];
  bit m_prev[N];

  function automatic bit m_exp(int i);
    return (m_lim[i] != 0) && (m_cnt[i] >= m_lim[i]);
  endfunction

  task automatic model_edge();
    bit mw, clr, act, e;
    mw = wr_en && (wr_src_ctx == 3'd0);
    for (int i = 0; i < N; i++) begin
      e   = m_exp(i);
      clr = (auto_clr_en && auto_clr_strobe) || (mw && wr_addr == 3'd5 && wr_data[i]);
      act = run_valid && (run_ctx == 3'(i)) && !e;
      if (clr) begin
        m_pre[i] = 0; m_cnt[i] = 0;
      end else if (act) begin
        if (m_pre[i] == 15) begin
          m_pre[i] = 0;
          if (m_cnt[i] < 65535) m_cnt[i]++;
        end else m_pre[i]++;
      end
      if (mw && wr_addr == 3'(i)) m_lim[i] = int'(wr_data);
      m_prev[i] = e;
    end
  endtask

  task automatic compare();
    logic [4:0] eh, ep;
    logic [2:0] ec;
    logic       ef;
    eh = '0; ep = '0; ec = '0;
    for (int i = 0; i < N; i++) begin
      eh[i] = m_exp(i);
      ep[i] = m_exp(i) && !m_prev[i];
    end
    for (int i = N - 1; i >= 0; i--) if (ep[i]) ec = 3'(i);
    ef = |ep;
    n_chk++;
    if (halt_req !== eh || timeout_pulse !== ep || fault_to_master !== ef ||
        (ef && fault_ctx !== ec)) begin
      n_bad++;
      $display("FAIL %s: halt=%b pulse=%b fault=%b ctx=%0d expected halt=%b pulse=%b fault=%b ctx=%0d",
               cur_req, halt_req, timeout_pulse, fault_to_master, fault_ctx, eh, ep, ef, ec);
    end
  endtask

  // one clock: model at the rising edge, compare at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    wr_en = 1'b0;
    auto_clr_strobe = 1'b0;
  endtask

  task automatic idle(int n);
    run_valid = 1'b0;
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr(logic [2:0] src, logic [2:0] addr, logic [15:0] data);
    run_valid = 1'b0;
    wr_en = 1'b1; wr_src_ctx = src; wr_addr = addr; wr_data = data;
    step();
  endtask

  task automatic run(int c, int n);
    run_valid = 1'b1; run_ctx = 3'(c);
    for (int k = 0; k < n; k++) step();
    run_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pre[i] = 0; m_cnt[i] = 0; m_lim[i] = 0; m_prev[i] = 0;
    end
    rst_n = 1'b0; run_valid = 1'b0; run_ctx = '0; wr_en = 1'b0;
    wr_src_ctx = '0; wr_addr = '0; wr_data = '0;
    auto_clr_en = 1'b0; auto_clr_strobe = 1'b0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    idle(5);

    // R2 / R4 / R5: limit sweep on every context
    cur_req = "R2";
    for (int c = 0; c < N; c++) begin
      for (int l = 1; l <= 4; l++) begin
        wr(3'd0, 3'(c), 16'(l));
        run(c, 16 * l - 1);
        cur_req = "R2";
        run(c, 1);
        cur_req = "R4";
        run(c, 20);
        idle(2);
        cur_req = "R5";
        wr(3'd0, 3'd5, 16'(1 << c));
        idle(1);
        cur_req = "R2";
      end
    end

    // R3: interleaving with gaps
    cur_req = "R3";
    wr(3'd0, 3'd1, 16'd2);
    wr(3'd0, 3'd2, 16'd3);
    for (int k = 0; k < 40; k++) begin
      run(1, 3);
      idle(k % 3);
      run(2, 5);
    end
    wr(3'd0, 3'd5, 16'h1f);

    // R6: zero limit never halts
    cur_req = "R6";
    wr(3'd0, 3'd4, 16'd0);
    run(4, 300);

    // R7: writes from non-master contexts are dropped
    cur_req = "R7";
    wr(3'd0, 3'd5, 16'h1f);
    wr(3'd3, 3'd0, 16'd1);
    run(0, 40);
    wr(3'd0, 3'd0, 16'd1);
    run(0, 16);
    wr(3'd2, 3'd5, 16'h1f);
    idle(2);
    wr(3'd1, 3'd0, 16'd0);
    idle(2);

    // R8: clear mask touches only the set bits
    cur_req = "R8";
    wr(3'd0, 3'd1, 16'd1);
    run(1, 16);
    wr(3'd0, 3'd5, 16'h01);
    idle(2);
    wr(3'd0, 3'd5, 16'h02);
    idle(2);
    run(1, 10);
    run(0, 16);
    wr(3'd0, 3'd5, 16'h1d);
    run(1, 6);
    idle(1);

    // R9: periodic timer clear
    cur_req = "R9";
    auto_clr_en = 1'b0;
    auto_clr_strobe = 1'b1;
    step();
    idle(1);
    auto_clr_en = 1'b1;
    auto_clr_strobe = 1'b1;
    step();
    idle(1);
    auto_clr_en = 1'b0;

    // R10: clear coinciding with a counter step
    cur_req = "R10";
    wr(3'd0, 3'd2, 16'd1);
    run(2, 15);
    run_valid = 1'b1; run_ctx = 3'd2;
    wr_en = 1'b1; wr_src_ctx = 3'd0; wr_addr = 3'd5; wr_data = 16'h04;
    step();
    run(2, 15);
    run(2, 2);
    wr(3'd0, 3'd5, 16'h1f);

    // R11: nothing advances for idle or out-of-range context numbers
    cur_req = "R11";
    for (int i = 0; i < N; i++) wr(3'd0, 3'(i), 16'd1);
    for (int c = 5; c < 8; c++) run(c, 40);
    idle(40);
    run(3, 16);
    idle(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule